// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins behind a simple word-wide register bus. Every transfer is one cycle: address, write enable and write data, with read data returned combinationally for the presented address. Each pin can be an input, a push-pull output, an open-drain output or a quasi-bidirectional pin. The bank drives pad output, output-enable and weak-pull-up signals for it. The block also brings each pin's live level back to software through a two-flop synchronizer.

Each pin has interrupt detection. A type bit picks edge or level sensing. Two independent enables arm the high/rising and the low/falling condition. Detected events latch into a per-pin source register that software clears by writing ones. All latched sources are ORed into one interrupt line. The pad electrical settings are plain read/write fields that only drive configuration ports: bias, slew, drive strength, input hysteresis, supply domain and debounce enable.

Top module: `gpio_bank16`

## Requirements
- R1: After reset every register reads 0, so every pin is an input (pad_oe all 0), all interrupts are disabled and irq is 0.
- R2: Pin n's mode is bits [2n+1:2n] of word 0x00. Mode 0 is input (pad_oe 0, pad_out 0, pad_weak_pu 0). Mode 1 is push-pull (pad_oe 1, pad_out equal to the data-out bit).
- R3: Mode 2 is open-drain and mode 3 is quasi-bidirectional. In both modes pad_oe equals the inverse of the data-out bit and pad_out is 0. In mode 3 pad_weak_pu equals the data-out bit, so pad_weak_pu and pad_oe are never both 1.
- R4: A write to 0x08 updates only the data-out bits whose mask bit (0x0C) is 0. Masked bits keep their value.
- R5: Reading 0x10 returns pin_in as it stood two clock edges earlier, with bits forced to 0 where the input-off register (0x04) holds 1. Forced-off pins see no edges.
- R6: With type bit n (0x18) at 0, the pin is edge sensed. Bit n of 0x1C arms falling edges and bit n+16 arms rising edges; both together catch both edges. A pin change before clock edge k shows in source register 0x20 after edge k+2.
- R7: With type bit n at 1, the pin is level sensed. The source bit is set on every cycle the armed level (bit n+16 high, bit n low) is present, so a clear does not remove it while the level holds.
- R8: Writing 1 to bit n of 0x20 clears source bit n and writing 0 leaves it. A new event in the same cycle wins over the clear.
- R9: irq is 1 exactly when at least one source bit is 1.
- R10: Drive strength is a 4-bit nibble per pin with 3 stored bits. Word 0x38 holds pins 0-7 and word 0x3C holds pins 8-15, and nibble bit 3 reads 0. cfg_drive carries pin n at [3n+2:3n].
- R11: Pull (0x30, 2 bits per pin: 0 none, 1 up, 2 down), slew (0x28, 2 bits per pin), hysteresis enable (0x24), supply domain (0x2C, 0 = 1.8 V, 1 = 3.3 V) and debounce enable (0x14) read back what was written and drive their ports unchanged. Bits above 15 of the one-bit-per-pin words read 0.
- R12: Addresses outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| bus_addr | input | 8 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 16 | Pin levels from the pads, asynchronous |
| pad_out | output | 16 | Strong output level per pin |
| pad_oe | output | 16 | Strong output enable per pin |
| pad_weak_pu | output | 16 | Weak pull-up request per pin (quasi mode) |
| irq | output | 1 | OR of all latched interrupt sources |
| cfg_pull | output | 32 | Bias select, 2 bits per pin |
| cfg_slew | output | 32 | Slew control, 2 bits per pin |
| cfg_drive | output | 48 | Drive strength, 3 bits per pin |
| cfg_schmitt | output | 16 | Input hysteresis enable per pin |
| cfg_supply | output | 16 | Supply domain per pin |
| cfg_debounce | output | 16 | Debounce enable per pin |

## Verification
The properties assume that the bus presents each write for a single cycle with a stable address. They also assume that a pin level stays long enough for the synchronizer to see it. A pulse shorter than one clock may vanish, and the edge and level checks say nothing about it. The stimulus changes pins and bus signals only on the falling clock edge and holds every pin level for at least three cycles. Source-clear writes with all enables off are the only case where the clear is checked to take effect completely.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    PM_INPUT     = 2'd0,
    PM_PUSHPULL  = 2'd1,
    PM_OPENDRAIN = 2'd2,
    PM_QUASI     = 2'd3
  } pin_mode_e;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_INOFF  = 8'h04;
  localparam logic [7:0] OFS_DOUT   = 8'h08;
  localparam logic [7:0] OFS_DMASK  = 8'h0C;
  localparam logic [7:0] OFS_PINV   = 8'h10;
  localparam logic [7:0] OFS_DBNC   = 8'h14;
  localparam logic [7:0] OFS_ITYPE  = 8'h18;
  localparam logic [7:0] OFS_IEN    = 8'h1C;
  localparam logic [7:0] OFS_ISRC   = 8'h20;
  localparam logic [7:0] OFS_SCHM   = 8'h24;
  localparam logic [7:0] OFS_SLEW   = 8'h28;
  localparam logic [7:0] OFS_SUPPLY = 8'h2C;
  localparam logic [7:0] OFS_PULL   = 8'h30;
  localparam logic [7:0] OFS_DRVLO  = 8'h38;
  localparam logic [7:0] OFS_DRVHI  = 8'h3C;
endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] async_in,
  output logic [NPIN-1:0] sync_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        stab_q <= meta_q;
      end
    end
    assign sync_out[i] = stab_q;
  end
endmodule

// File: rtl/gpio_bank_irq.sv
`timescale 1ns/1ps
module gpio_bank_irq #(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   samp,
  input  logic [NPIN-1:0]   itype,
  input  logic [2*NPIN-1:0] ien,
  input  logic [NPIN-1:0]   clr,
  output logic [NPIN-1:0]   isrc
);
  logic [NPIN-1:0] prev_q, prev_n;
  logic [NPIN-1:0] isrc_q, isrc_n;
  logic [NPIN-1:0] rise, fall, hi_hit, lo_hit, set_v;
  logic [NPIN-1:0] en_lo, en_hi;

  assign en_lo = ien[NPIN-1:0];
  assign en_hi = ien[2*NPIN-1:NPIN];

  always_comb begin
    rise   = samp & ~prev_q;
    fall   = ~samp & prev_q;
    hi_hit = (itype & samp)  | (~itype & rise);
    lo_hit = (itype & ~samp) | (~itype & fall);
    set_v  = (en_hi & hi_hit) | (en_lo & lo_hit);
    isrc_n = (isrc_q & ~clr) | set_v;
    prev_n = samp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      isrc_q <= '0;
    end else begin
      prev_q <= prev_n;
      isrc_q <= isrc_n;
    end
  end

  assign isrc = isrc_q;
endmodule

// File: rtl/gpio_bank_pads.sv
`timescale 1ns/1ps
module gpio_bank_pads import gpio_bank_pkg::*; #(
  parameter int NPIN = 16
) (
  input  logic [2*NPIN-1:0] mode,
  input  logic [NPIN-1:0]   dout,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_weak_pu
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pin_mode_e pm;
    logic      o_v, oe_v, wk_v;
    assign pm = pin_mode_e'(mode[2*i +: 2]);
    always_comb begin
      o_v  = 1'b0;
      oe_v = 1'b0;
      wk_v = 1'b0;
      case (pm)
        PM_PUSHPULL: begin
          oe_v = 1'b1;
          o_v  = dout[i];
        end
        PM_OPENDRAIN: oe_v = ~dout[i];
        PM_QUASI: begin
          oe_v = ~dout[i];
          wk_v = dout[i];
        end
        default: ;
      endcase
    end
    assign pad_out[i]     = o_v;
    assign pad_oe[i]      = oe_v;
    assign pad_weak_pu[i] = wk_v;
  end
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs import gpio_bank_pkg::*; #(
  parameter int NPIN   = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DS_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NPIN-1:0]      pin_val,
  input  logic [NPIN-1:0]      isrc,
  output logic [NPIN-1:0]      isrc_clr,
  output logic [2*NPIN-1:0]    mode_q,
  output logic [NPIN-1:0]      inoff_q,
  output logic [NPIN-1:0]      dout_q,
  output logic [NPIN-1:0]      dmask_q,
  output logic [NPIN-1:0]      itype_q,
  output logic [2*NPIN-1:0]    ien_q,
  output logic [NPIN-1:0]      dbnc_q,
  output logic [NPIN-1:0]      schm_q,
  output logic [2*NPIN-1:0]    slew_q,
  output logic [NPIN-1:0]      supply_q,
  output logic [2*NPIN-1:0]    pull_q,
  output logic [NPIN*DS_W-1:0] drv_q
);
  localparam int MODE_W = 2 * NPIN;
  localparam int NIB    = DATA_W / 4;
  localparam int LO_CNT = (NPIN < NIB) ? NPIN : NIB;
  localparam int HI_CNT = NPIN - LO_CNT;
  localparam int DRV_W  = NPIN * DS_W;

  logic [MODE_W-1:0] mode_n, ien_n, slew_n, pull_n;
  logic [NPIN-1:0]   inoff_n, dout_n, dmask_n, itype_n, dbnc_n, schm_n, supply_n;
  logic [DRV_W-1:0]  drv_n;

  always_comb begin
    mode_n   = mode_q;
    inoff_n  = inoff_q;
    dout_n   = dout_q;
    dmask_n  = dmask_q;
    itype_n  = itype_q;
    ien_n    = ien_q;
    dbnc_n   = dbnc_q;
    schm_n   = schm_q;
    slew_n   = slew_q;
    supply_n = supply_q;
    pull_n   = pull_q;
    drv_n    = drv_q;
    isrc_clr = '0;
    if (bus_we) begin
      case (bus_addr)
        ADDR_W'(OFS_MODE):   mode_n   = bus_wdata[MODE_W-1:0];
        ADDR_W'(OFS_INOFF):  inoff_n  = bus_wdata[NPIN-1:0];
        ADDR_W'(OFS_DOUT):   dout_n   = (dout_q & dmask_q) | (bus_wdata[NPIN-1:0] & ~dmask_q);
        ADDR_W'(OFS_DMASK):  dmask_n  = bus_wdata[NPIN-1:0];
        ADDR_W'(OFS_DBNC):   dbnc_n   = bus_wdata[NPIN-1:0];
        ADDR_W'(OFS_ITYPE):  itype_n  = bus_wdata[NPIN-1:0];
        ADDR_W'(OFS_IEN):    ien_n    = bus_wdata[MODE_W-1:0];
        ADDR_W'(OFS_ISRC):   isrc_clr = bus_wdata[NPIN-1:0];
        ADDR_W'(OFS_SCHM):   schm_n   = bus_wdata[NPIN-1:0];
        ADDR_W'(OFS_SLEW):   slew_n   = bus_wdata[MODE_W-1:0];
        ADDR_W'(OFS_SUPPLY): supply_n = bus_wdata[NPIN-1:0];
        ADDR_W'(OFS_PULL):   pull_n   = bus_wdata[MODE_W-1:0];
        ADDR_W'(OFS_DRVLO): begin
          for (int p = 0; p < LO_CNT; p++)
            drv_n[p*DS_W +: DS_W] = bus_wdata[4*p +: DS_W];
        end
        ADDR_W'(OFS_DRVHI): begin
          for (int h = 0; h < HI_CNT; h++)
            drv_n[(h+LO_CNT)*DS_W +: DS_W] = bus_wdata[4*h +: DS_W];
        end
        default: ;
      endcase
    end
  end

  // Register bank: loads only on a bus write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      inoff_q  <= '0;
      dout_q   <= '0;
      dmask_q  <= '0;
      itype_q  <= '0;
      ien_q    <= '0;
      dbnc_q   <= '0;
      schm_q   <= '0;
      slew_q   <= '0;
      supply_q <= '0;
      pull_q   <= '0;
      drv_q    <= '0;
    end else if (bus_we) begin
      mode_q   <= mode_n;
      inoff_q  <= inoff_n;
      dout_q   <= dout_n;
      dmask_q  <= dmask_n;
      itype_q  <= itype_n;
      ien_q    <= ien_n;
      dbnc_q   <= dbnc_n;
      schm_q   <= schm_n;
      slew_q   <= slew_n;
      supply_q <= supply_n;
      pull_q   <= pull_n;
      drv_q    <= drv_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_MODE):   bus_rdata[MODE_W-1:0] = mode_q;
      ADDR_W'(OFS_INOFF):  bus_rdata[NPIN-1:0]   = inoff_q;
      ADDR_W'(OFS_DOUT):   bus_rdata[NPIN-1:0]   = dout_q;
      ADDR_W'(OFS_DMASK):  bus_rdata[NPIN-1:0]   = dmask_q;
      ADDR_W'(OFS_PINV):   bus_rdata[NPIN-1:0]   = pin_val;
      ADDR_W'(OFS_DBNC):   bus_rdata[NPIN-1:0]   = dbnc_q;
      ADDR_W'(OFS_ITYPE):  bus_rdata[NPIN-1:0]   = itype_q;
      ADDR_W'(OFS_IEN):    bus_rdata[MODE_W-1:0] = ien_q;
      ADDR_W'(OFS_ISRC):   bus_rdata[NPIN-1:0]   = isrc;
      ADDR_W'(OFS_SCHM):   bus_rdata[NPIN-1:0]   = schm_q;
      ADDR_W'(OFS_SLEW):   bus_rdata[MODE_W-1:0] = slew_q;
      ADDR_W'(OFS_SUPPLY): bus_rdata[NPIN-1:0]   = supply_q;
      ADDR_W'(OFS_PULL):   bus_rdata[MODE_W-1:0] = pull_q;
      ADDR_W'(OFS_DRVLO): begin
        for (int p = 0; p < LO_CNT; p++)
          bus_rdata[4*p +: DS_W] = drv_q[p*DS_W +: DS_W];
      end
      ADDR_W'(OFS_DRVHI): begin
        for (int h = 0; h < HI_CNT; h++)
          bus_rdata[4*h +: DS_W] = drv_q[(h+LO_CNT)*DS_W +: DS_W];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_bank16.sv
`timescale 1ns/1ps
module gpio_bank16 import gpio_bank_pkg::*; #(
  parameter int NPIN   = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DS_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NPIN-1:0]      pin_in,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_weak_pu,
  output logic                 irq,
  output logic [2*NPIN-1:0]    cfg_pull,
  output logic [2*NPIN-1:0]    cfg_slew,
  output logic [NPIN*DS_W-1:0] cfg_drive,
  output logic [NPIN-1:0]      cfg_schmitt,
  output logic [NPIN-1:0]      cfg_supply,
  output logic [NPIN-1:0]      cfg_debounce
);
  logic rst_m_q, rst_int_n;
  logic [NPIN-1:0]   sync_v, samp, isrc_q, isrc_clr;
  logic [2*NPIN-1:0] mode_q, ien_q;
  logic [NPIN-1:0]   inoff_q, dout_q, dmask_q, itype_q;

  // Asynchronous assertion, release on the clock after two stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q   <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_m_q   <= 1'b1;
      rst_int_n <= rst_m_q;
    end
  end

  gpio_bank_sync #(.NPIN(NPIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pin_in),
    .sync_out (sync_v)
  );

  assign samp = sync_v & ~inoff_q;

  gpio_bank_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DS_W(DS_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_val   (samp),
    .isrc      (isrc_q),
    .isrc_clr  (isrc_clr),
    .mode_q    (mode_q),
    .inoff_q   (inoff_q),
    .dout_q    (dout_q),
    .dmask_q   (dmask_q),
    .itype_q   (itype_q),
    .ien_q     (ien_q),
    .dbnc_q    (cfg_debounce),
    .schm_q    (cfg_schmitt),
    .slew_q    (cfg_slew),
    .supply_q  (cfg_supply),
    .pull_q    (cfg_pull),
    .drv_q     (cfg_drive)
  );

  gpio_bank_irq #(.NPIN(NPIN)) u_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .samp  (samp),
    .itype (itype_q),
    .ien   (ien_q),
    .clr   (isrc_clr),
    .isrc  (isrc_q)
  );

  gpio_bank_pads #(.NPIN(NPIN)) u_pads (
    .mode        (mode_q),
    .dout        (dout_q),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_weak_pu (pad_weak_pu)
  );

  assign irq = |isrc_q;
endmodule

// File: rtl/gpio_bank16_chk.sv
`timescale 1ns/1ps
module gpio_bank16_chk import gpio_bank_pkg::*; #(
  parameter int NPIN   = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_weak_pu,
  input logic [2*NPIN-1:0] ien_q,
  input logic [NPIN-1:0]   itype_q,
  input logic [NPIN-1:0]   isrc_q,
  input logic [NPIN-1:0]   samp,
  input logic [NPIN-1:0]   dout_q,
  input logic [NPIN-1:0]   dmask_q
);
  logic wr_dout, wr_isrc;
  assign wr_dout = bus_we && (bus_addr == ADDR_W'(OFS_DOUT));
  assign wr_isrc = bus_we && (bus_addr == ADDR_W'(OFS_ISRC));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (!irq && pad_oe == '0)); // R1

  AST_WEAK_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (pad_weak_pu & pad_oe) == '0); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    wr_dout |=> ((dout_q ^ $past(dout_q)) & $past(dmask_q)) == '0); // R4

  AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    !wr_dout |=> $stable(dout_q)); // R4

  AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    1'b1 |=> (($past(itype_q & ien_q[2*NPIN-1:NPIN] & samp) & ~isrc_q) == '0)); // R7

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (wr_isrc && ien_q == '0) |=> (isrc_q & $past(bus_wdata[NPIN-1:0])) == '0); // R8

  AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    !wr_isrc |=> ($past(isrc_q) & ~isrc_q) == '0); // R8

  AST_IRQ_MATCHES_SRC: assert property (@(posedge clk) disable iff (!rst_n || !rst_int_n)
    (bus_addr == ADDR_W'(OFS_ISRC)) |-> (irq == (bus_rdata != '0))); // R9
endmodule

bind gpio_bank16 gpio_bank16_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_int_n   (rst_int_n),
  .bus_addr    (bus_addr),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq         (irq),
  .pad_oe      (pad_oe),
  .pad_weak_pu (pad_weak_pu),
  .ien_q       (ien_q),
  .itype_q     (itype_q),
  .isrc_q      (isrc_q),
  .samp        (samp),
  .dout_q      (dout_q),
  .dmask_q     (dmask_q)
);

// File: tb/gpio_bank16_tb_top.sv
`timescale 1ns/1ps
module gpio_bank16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pad_out, pad_oe, pad_weak_pu;
  logic        irq;
  logic [31:0] cfg_pull, cfg_slew;
  logic [47:0] cfg_drive;
  logic [15:0] cfg_schmitt, cfg_supply, cfg_debounce;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_bank16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_weak_pu(pad_weak_pu), .irq(irq),
    .cfg_pull(cfg_pull), .cfg_slew(cfg_slew), .cfg_drive(cfg_drive),
    .cfg_schmitt(cfg_schmitt), .cfg_supply(cfg_supply), .cfg_debounce(cfg_debounce)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        mr1 = 1'b0, mr2 = 1'b0;
  logic [31:0] m_mode, m_ien, m_slew, m_pull;
  logic [15:0] m_inoff, m_dout, m_dmask, m_dbnc, m_itype, m_isrc, m_schm, m_supply;
  logic [15:0] m_s1, m_s2, m_prev;
  logic [47:0] m_drv;

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      8'h00: r = m_mode;
      8'h04: r = {16'h0, m_inoff};
      8'h08: r = {16'h0, m_dout};
      8'h0C: r = {16'h0, m_dmask};
      8'h10: r = {16'h0, m_s2 & ~m_inoff};
      8'h14: r = {16'h0, m_dbnc};
      8'h18: r = {16'h0, m_itype};
      8'h1C: r = m_ien;
      8'h20: r = {16'h0, m_isrc};
      8'h24: r = {16'h0, m_schm};
      8'h28: r = m_slew;
      8'h2C: r = {16'h0, m_supply};
      8'h30: r = m_pull;
      8'h38: for (int p = 0; p < 8; p++) r[4*p +: 3] = m_drv[3*p +: 3];
      8'h3C: for (int p = 0; p < 8; p++) r[4*p +: 3] = m_drv[3*(p+8) +: 3];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h08, 8'h0C: return "R4";
      8'h04, 8'h10: return "R5";
      8'h18, 8'h1C: return "R6";
      8'h20: return "R8";
      8'h38, 8'h3C: return "R10";
      8'h14, 8'h24, 8'h28, 8'h2C, 8'h30: return "R11";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [15:0] s, set_v, hi, lo, clr;
    logic [15:0] e_out, e_oe, e_wk;
    if (!rst_n) begin mr1 = 1'b0; mr2 = 1'b0; end
    if (!mr2) begin
      m_mode = '0; m_ien = '0; m_slew = '0; m_pull = '0; m_inoff = '0; m_dout = '0;
      m_dmask = '0; m_dbnc = '0; m_itype = '0; m_isrc = '0; m_schm = '0; m_supply = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_drv = '0;
    end else begin
      s   = m_s2 & ~m_inoff;
      hi  = (m_itype & s)  | (~m_itype & s & ~m_prev);
      lo  = (m_itype & ~s) | (~m_itype & ~s & m_prev);
      set_v = (m_ien[31:16] & hi) | (m_ien[15:0] & lo);
      clr = (bus_we && bus_addr == 8'h20) ? bus_wdata[15:0] : 16'h0;
      m_isrc = (m_isrc & ~clr) | set_v;
      m_prev = s;
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_mode = bus_wdata;
          8'h04: m_inoff = bus_wdata[15:0];
          8'h08: m_dout = (m_dout & m_dmask) | (bus_wdata[15:0] & ~m_dmask);
          8'h0C: m_dmask = bus_wdata[15:0];
          8'h14: m_dbnc = bus_wdata[15:0];
          8'h18: m_itype = bus_wdata[15:0];
          8'h1C: m_ien = bus_wdata;
          8'h24: m_schm = bus_wdata[15:0];
          8'h28: m_slew = bus_wdata;
          8'h2C: m_supply = bus_wdata[15:0];
          8'h30: m_pull = bus_wdata;
          8'h38: for (int p = 0; p < 8; p++) m_drv[3*p +: 3] = bus_wdata[4*p +: 3];
          8'h3C: for (int p = 0; p < 8; p++) m_drv[3*(p+8) +: 3] = bus_wdata[4*p +: 3];
          default: ;
        endcase
      end
    end
    mr2 = mr1;
    mr1 = rst_n;
    for (int p = 0; p < 16; p++) begin
      case (m_mode[2*p +: 2])
        2'd1: begin e_oe[p] = 1'b1; e_out[p] = m_dout[p]; e_wk[p] = 1'b0; end
        2'd2: begin e_oe[p] = ~m_dout[p]; e_out[p] = 1'b0; e_wk[p] = 1'b0; end
        2'd3: begin e_oe[p] = ~m_dout[p]; e_out[p] = 1'b0; e_wk[p] = m_dout[p]; end
        default: begin e_oe[p] = 1'b0; e_out[p] = 1'b0; e_wk[p] = 1'b0; end
      endcase
    end
    #1;
    chk(tag_of(bus_addr), 64'(bus_rdata), 64'(mread(bus_addr)));
    chk("R2", 64'(pad_out), 64'(e_out));
    chk("R3", 64'(pad_oe), 64'(e_oe));
    chk("R3", 64'(pad_weak_pu), 64'(e_wk));
    chk("R9", 64'(irq), 64'(m_isrc != 16'h0));
    chk("R10", 64'(cfg_drive), 64'(m_drv));
    chk("R11", {cfg_slew, cfg_pull}, {m_slew, m_pull});
    chk("R11", {16'h0, cfg_schmitt, cfg_supply, cfg_debounce}, {16'h0, m_schm, m_supply, m_dbnc});
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    logic [31:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    rd(8'h00, v); chk("R1", 64'(v), 64'h0);
    chk("R1", {47'h0, irq, pad_oe}, 64'h0);
    // R2 / R3 pin modes
    wr(8'h00, 32'h0000_00E4);
    wr(8'h08, 32'h0000_000E);
    chk("R2", 64'(pad_out[3:0]), 64'h2);
    chk("R3", 64'(pad_oe[3:0]), 64'h2);
    chk("R3", 64'(pad_weak_pu[3:0]), 64'h8);
    wr(8'h08, 32'h0);
    chk("R3", 64'(pad_oe[3:0]), 64'hE);
    // R4 write mask
    wr(8'h0C, 32'h0000_0002);
    wr(8'h08, 32'h0000_FFFF);
    rd(8'h08, v); chk("R4", 64'(v), 64'hFFFD);
    wr(8'h0C, 32'h0);
    wr(8'h08, 32'h0);
    // R5 pin readback and input-off
    @(negedge clk); pin_in = 16'hA5A5;
    tick(3);
    rd(8'h10, v); chk("R5", 64'(v), 64'hA5A5);
    wr(8'h04, 32'h0000_00FF);
    rd(8'h10, v); chk("R5", 64'(v), 64'hA500);
    wr(8'h04, 32'h0);
    @(negedge clk); pin_in = 16'h0;
    tick(4);
    // R6 edge detection
    wr(8'h20, 32'h0000_FFFF);
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h0001_0000);
    pin_in[0] = 1'b1;
    tick(2); chk("R6", 64'(irq), 64'h0);
    tick(1); chk("R6", 64'(irq), 64'h1);
    rd(8'h20, v); chk("R6", 64'(v), 64'h1);
    @(negedge clk); pin_in[0] = 1'b0;
    wr(8'h20, 32'h1);
    tick(4); chk("R6", 64'(irq), 64'h0);
    wr(8'h1C, 32'h0001_0001);
    pin_in[0] = 1'b1;
    tick(3); chk("R6", 64'(irq), 64'h1);
    wr(8'h20, 32'h1);
    chk("R8", 64'(irq), 64'h0);
    pin_in[0] = 1'b0;
    tick(3); chk("R6", 64'(irq), 64'h1);
    // R8 write-zero keeps, write-one clears; R9 OR
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk("R8", 64'(v), 64'h1);
    wr(8'h20, 32'h1);
    rd(8'h20, v); chk("R8", 64'(v), 64'h0);
    chk("R9", 64'(irq), 64'h0);
    wr(8'h1C, 32'h0011_0000);
    pin_in = 16'h0011;
    tick(3);
    rd(8'h20, v); chk("R9", 64'(v), 64'h11);
    wr(8'h20, 32'h1);
    chk("R9", 64'(irq), 64'h1);
    wr(8'h20, 32'h10);
    chk("R9", 64'(irq), 64'h0);
    // R7 level detection
    wr(8'h18, 32'h0000_0002);
    wr(8'h1C, 32'h0002_0000);
    pin_in[1] = 1'b1;
    tick(3);
    rd(8'h20, v); chk("R7", 64'(v), 64'h2);
    wr(8'h20, 32'h2);
    rd(8'h20, v); chk("R7", 64'(v), 64'h2);
    @(negedge clk); pin_in[1] = 1'b0;
    tick(3);
    wr(8'h20, 32'h2);
    rd(8'h20, v); chk("R7", 64'(v), 64'h0);
    // R10 drive strength
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, v); chk("R10", 64'(v), 64'h7777_7777);
    chk("R10", 64'(cfg_drive[23:0]), 64'hFF_FFFF);
    wr(8'h3C, 32'h0000_0005);
    chk("R10", 64'(cfg_drive[26:24]), 64'h5);
    // R11 pad configuration
    wr(8'h30, 32'h0000_0009);
    rd(8'h30, v); chk("R11", 64'(v), 64'h9);
    chk("R11", 64'(cfg_pull), 64'h9);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R11", 64'(v), 64'hFFFF);
    wr(8'h2C, 32'h1);
    chk("R11", 64'(cfg_supply), 64'h1);
    wr(8'h28, 32'h30);
    chk("R11", 64'(cfg_slew), 64'h30);
    wr(8'h14, 32'hABCD);
    chk("R11", 64'(cfg_debounce), 64'hABCD);
    // R12 unmapped address
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); chk("R12", 64'(v), 64'h0);
    rd(8'h00, v); chk("R12", 64'(v), 64'hE4);
    tick(4);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule